// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic tick timer that software reaches through three 32-bit memory-mapped registers: a control/status word, a reload word and a current-count word. Once software enables it, a 24-bit counter steps down by one on every selected tick. The tick source is either every processor clock or each rising edge of an external reference input, which the block synchronises first. When the counter is at zero and the next tick arrives, it takes the reload value again, so with reload N the period is N+1 ticks.

Each step from one to zero sets a sticky wrap flag. If software has enabled it, the same step also sends a one-cycle exception request to the interrupt controller. Reading the control/status word clears the flag. Writing any value to the current-count word clears both the counter and the flag and raises no request. Register reads are combinational: `bus_rdata` is valid in the same cycle as `bus_sel` and is zero when no read is in progress.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and `tick_irq` is low.
- R2: The control/status word is at base+0x10. Bit 0 enables counting, bit 1 enables the exception request and bit 2 selects the tick source (1 = processor clock, 0 = external reference). These three bits read back as written. Every other bit reads zero, except bit 16, which is the wrap flag.
- R3: The reload word at base+0x14 stores only bits 23:0 of a write. Bits 31:24 are ignored and read zero.
- R4: With bit 0 set and bit 2 set, the current-count word (base+0x18, bits 23:0) drops by one on every clock edge. With bit 0 clear, it holds its value.
- R5: A tick that finds the counter at zero loads the reload value, so counting repeats with a period of reload+1 ticks. The load uses the reload value held before that edge.
- R6: A tick that moves the counter from 1 to 0 sets the wrap flag (control bit 16) at that edge.
- R7: A read of the control/status word returns the flag and clears it at that edge. If a wrap happens at the same edge, the flag stays set.
- R8: When control bit 1 was set before the edge at which a wrap happens, `tick_irq` is high for exactly the one cycle after that edge. When bit 1 is clear, `tick_irq` stays low.
- R9: A write of any data to base+0x18 clears the counter and the wrap flag at that edge and raises no request, even if a wrap would have happened at that edge.
- R10: With a reload value of zero, the counter holds at zero and no further wraps happen.
- R11: With bit 2 clear, each rising edge of `ref_tick` gives exactly one tick. The input is captured at a clock edge, and the count changes at the second clock edge after that one. A level held high gives no more ticks.
- R12: Any address other than the three register words reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in progress this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| ref_tick | input | 1 | External reference tick, asynchronous |
| tick_irq | output | 1 | One-cycle exception request on each enabled wrap |

## Verification
The assertions assume that the bus inputs are stable at each rising clock edge and that an access lasts exactly one cycle, so a single read clears the flag only once. The bench drives every input on the falling edge and holds each access for a single cycle. It also holds `ref_tick` at each level for at least one clock. The synchroniser checks depend on this, because they expect each sampled rising edge to be seen once.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam logic [31:0] OFF_CTRL   = 32'h10;
    localparam logic [31:0] OFF_RELOAD = 32'h14;
    localparam logic [31:0] OFF_COUNT  = 32'h18;
    localparam int          FLAG_BIT   = 16;

    typedef struct packed {
        logic clk_sel;   // bit 2: 1 = processor clock
        logic irq_en;    // bit 1
        logic enable;    // bit 0
    } ctrl_t;
endpackage

// File: rtl/tt_tick_sync.sv
module tt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[W-2:0], async_i};
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R11: one synchronised edge gives a single tick
    a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload_i;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                wrap_o   = (st_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    a_r4_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - ONE));
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0));
    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && reload_i == '0) |=> (st_q.cnt == '0));
endmodule

// File: rtl/tt_reg_bank.sv
module tt_reg_bank
    import tt_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'hE000_E000,
    parameter int          CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [31:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] count_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             count_clr_o,
    output logic             irq_o
);
    localparam logic [31:0] A_CTRL   = BASE + OFF_CTRL;
    localparam logic [31:0] A_RELOAD = BASE + OFF_RELOAD;
    localparam logic [31:0] A_COUNT  = BASE + OFF_COUNT;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
        logic             flag;
        logic             irq;
    } rb_st_t;

    rb_st_t st_d, st_q;
    logic   hit_ctrl, hit_reload, hit_count;
    logic   rd_ctrl, wr_ctrl, wr_reload;
    logic   unused_wbits;

    assign unused_wbits = ^bus_wdata[31:CNT_W];

    always_comb begin
        hit_ctrl    = bus_sel && (bus_addr == A_CTRL);
        hit_reload  = bus_sel && (bus_addr == A_RELOAD);
        hit_count   = bus_sel && (bus_addr == A_COUNT);
        rd_ctrl     = hit_ctrl && !bus_wr;
        wr_ctrl     = hit_ctrl && bus_wr;
        wr_reload   = hit_reload && bus_wr;
        count_clr_o = hit_count && bus_wr;

        st_d = st_q;
        if (wr_ctrl)   st_d.ctrl   = ctrl_t'(bus_wdata[2:0]);
        if (wr_reload) st_d.reload = bus_wdata[CNT_W-1:0];
        if (count_clr_o)  st_d.flag = 1'b0;
        else if (wrap_i)  st_d.flag = 1'b1;
        else if (rd_ctrl) st_d.flag = 1'b0;
        st_d.irq = wrap_i && st_q.ctrl.irq_en;

        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl) begin
                bus_rdata[2:0]      = st_q.ctrl;
                bus_rdata[FLAG_BIT] = st_q.flag;
            end else if (hit_reload) begin
                bus_rdata[CNT_W-1:0] = st_q.reload;
            end else if (hit_count) begin
                bus_rdata[CNT_W-1:0] = count_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign reload_o = st_q.reload;
    assign irq_o    = st_q.irq;

    a_r6_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> st_q.flag);
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);
    a_r8_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> st_q.flag);
    a_r9_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        count_clr_o |=> !st_q.flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter logic [31:0] BASE        = 32'hE000_E000,
    parameter int          CNT_W       = 24,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_tick,
    output logic        tick_irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count;
    logic             count_clr, wrap, ref_rise, step;

    tt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_tick),
        .rise_o  (ref_rise)
    );

    assign step = ctrl.enable && (ctrl.clk_sel || ref_rise);

    tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .clear_i  (count_clr),
        .reload_i (reload),
        .count_o  (count),
        .wrap_o   (wrap)
    );

    tt_reg_bank #(.BASE(BASE), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wrap_i      (wrap),
        .count_i     (count),
        .ctrl_o      (ctrl),
        .reload_o    (reload),
        .count_clr_o (count_clr),
        .irq_o       (tick_irq)
    );

    // R8: no request while the enable bit is clear
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> $past(ctrl.irq_en));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    localparam logic [31:0] A_CTRL = 32'hE000_E010;
    localparam logic [31:0] A_REL  = 32'hE000_E014;
    localparam logic [31:0] A_CNT  = 32'hE000_E018;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, ref_tick = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_tick(ref_tick), .tick_irq(tick_irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    bit m_en, m_ie, m_cs, m_flag, m_irq;
    int m_rel, m_cur;
    bit h0, h1, h2;
    bit rise, step, rdc, wcv, wrap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_irq = 0;
            m_rel = 0; m_cur = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            rise = h1 && !h2;
            h2 = h1; h1 = h0; h0 = ref_tick;
            step = m_en && (m_cs || rise);
            rdc  = bus_sel && !bus_wr && bus_addr == A_CTRL;
            wcv  = bus_sel && bus_wr && bus_addr == A_CNT;
            wrap = step && m_cur == 1 && !wcv;
            m_irq = wrap && m_ie;
            if (wcv) m_cur = 0;
            else if (step) m_cur = (m_cur == 0) ? m_rel : m_cur - 1;
            if (wcv) m_flag = 0;
            else if (wrap) m_flag = 1;
            else if (rdc) m_flag = 0;
            if (bus_sel && bus_wr && bus_addr == A_CTRL) begin
                m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_cs = bus_wdata[2];
            end
            if (bus_sel && bus_wr && bus_addr == A_REL) m_rel = int'(bus_wdata & 32'h00FF_FFFF);
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!bus_sel || bus_wr) return '0;
        if (bus_addr == A_CTRL) return {15'd0, m_flag, 13'd0, m_cs, m_ie, m_en};
        if (bus_addr == A_REL)  return 32'(m_rel);
        if (bus_addr == A_CNT)  return 32'(m_cur);
        return '0; // R12
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1.5;
        if (rst_n) begin
            chk(bus_rdata, exp_rdata(), "bus_rdata");
            chk({31'd0, tick_irq}, {31'd0, m_irq}, "tick_irq");
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [31:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        rd(A_CTRL); rd(A_REL); rd(A_CNT);

        cur_req = "R2";
        wr(A_CTRL, 32'hFFFF_FFF6); rd(A_CTRL);
        wr(A_CTRL, 32'h0); rd(A_CTRL);

        cur_req = "R3";
        wr(A_REL, 32'hAB12_3456); rd(A_REL);
        wr(A_REL, 32'd4); rd(A_REL);

        cur_req = "R4";
        wr(A_CTRL, 32'h5);
        for (int i = 0; i < 6; i++) rd(A_CNT);
        wr(A_CTRL, 32'h4);
        rd(A_CNT); idle(3); rd(A_CNT);

        cur_req = "R5";
        wr(A_CTRL, 32'h5);
        for (int i = 0; i < 12; i++) rd(A_CNT);

        cur_req = "R6";
        idle(4); rd(A_CTRL);
        cur_req = "R7";
        rd(A_CTRL);
        wr(A_REL, 32'd2);
        for (int i = 0; i < 12; i++) rd(A_CTRL);

        cur_req = "R8";
        wr(A_CTRL, 32'h7);
        for (int i = 0; i < 10; i++) rd(A_CNT);
        idle(8);
        wr(A_CTRL, 32'h5);
        idle(8);

        cur_req = "R9";
        wr(A_CTRL, 32'h7);
        wr(A_REL, 32'd20);
        idle(5);
        wr(A_CNT, 32'h55);
        rd(A_CNT); rd(A_CTRL);
        for (int i = 0; i < 8; i++) wr(A_CNT, 32'(i));
        rd(A_CTRL);

        cur_req = "R10";
        wr(A_REL, 32'd0);
        idle(30);
        rd(A_CNT); rd(A_CTRL); rd(A_CNT);

        cur_req = "R11";
        wr(A_REL, 32'd3);
        wr(A_CTRL, 32'h3);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) ref_tick = 1;
            rd(A_CNT);
            @(negedge clk) ref_tick = 0;
            rd(A_CNT);
        end
        @(negedge clk) ref_tick = 1;
        for (int i = 0; i < 6; i++) rd(A_CNT);
        @(negedge clk) ref_tick = 0;
        idle(4);

        cur_req = "R12";
        wr(A_CTRL, 32'h0);
        wr(32'hE000_E01C, 32'hFFFF_FFFF); rd(32'hE000_E01C);
        wr(32'hE000_E000, 32'h7); rd(32'hE000_E000);
        rd(A_CTRL); rd(A_REL); rd(A_CNT);

        idle(4);
        finish_run();
    end
endmodule